// File: doc/BRIEF.md
# Strap Output Router with Held Bit

This block routes a small stored configuration word onto board-level strap outputs. Four routed outputs take either the low four bits of the stored word or a 4-bit external input bus, as chosen by one source-select line. A fifth output carries the stored word's top bit through a level-sensitive hold latch. The latch is open while the stored word is selected and closed while the external bus is selected. The stored word can therefore be rewritten by a separate register block while the external source is in use, and the held output does not move.

An active-low force line pulls every output to zero, but only while the stored word is selected. While the external bus is selected, the force line has no effect. The latch captures the held output's visible value, so a bit that was forced to zero when the select rose stays zero. The latch is also cleared by the asynchronous active-low reset.

Top module: `strap_route`

## Requirements
- R1: With use_ext_i=0 and force_n_i=1, route_o equals cfg_word_i[3:0], with route_o[0] carrying cfg_word_i[0] and route_o[3] carrying cfg_word_i[3].
- R2: With use_ext_i=1, route_o equals ext_i whatever the level of force_n_i.
- R3: With use_ext_i=0, force_n_i=1 and reset released, held_o equals cfg_word_i[4] and follows it with no clock.
- R4: While use_ext_i=1, held_o keeps the value it showed just before use_ext_i rose, and changes to cfg_word_i do not alter it.
- R5: With use_ext_i=0 and force_n_i=0, route_o is 0 and held_o is 0.
- R6: Pulling force_n_i low while use_ext_i=1 leaves both route_o and held_o unchanged. If force_n_i was 0 when use_ext_i rose, held_o stays 0 until use_ext_i falls, even if force_n_i is released.
- R7: When use_ext_i returns to 0 with force_n_i=1, held_o takes cfg_word_i[4] at once.
- R8: While rst_ni=0, held_o is 0 for any level of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of the hold latch |
| cfg_word_i | input | 5 | Stored configuration word: bit 4 feeds held_o, bits 3..0 feed route_o |
| ext_i | input | 4 | External source for route_o |
| use_ext_i | input | 1 | 1 selects ext_i and closes the hold latch; 0 selects the stored word and opens it |
| force_n_i | input | 1 | Active-low force to zero, effective only while use_ext_i=0 |
| route_o | output | 4 | Routed outputs |
| held_o | output | 1 | Latched copy of the stored word's top bit |

## Verification
Two functions can act in the same instant: the force line pulls the held bit to zero, and the hold latch closes as use_ext_i rises. The bench drives force_n_i low with cfg_word_i[4]=1, then raises use_ext_i while the force is still low. The check passes only if held_o stays 0 after the force is released and only takes 1 once use_ext_i falls. A design that latched the raw stored bit instead of the visible output would show 1 early.

// File: rtl/strap_route_pkg.sv
package strap_route_pkg;
  typedef enum logic {
    SRC_REG = 1'b0,
    SRC_EXT = 1'b1
  } route_src_e;

  function automatic logic gate_bit(input logic val, input logic force_n);
    return val & force_n;
  endfunction
endpackage

// File: rtl/strap_lane.sv
module strap_lane
  import strap_route_pkg::*;
(
  input  logic       reg_bit_i,
  input  logic       ext_bit_i,
  input  route_src_e src_i,
  input  logic       force_n_i,
  output logic       out_o
);
  always_comb begin
    unique case (src_i)
      SRC_EXT: out_o = ext_bit_i;
      default: out_o = gate_bit(reg_bit_i, force_n_i);
    endcase
  end
endmodule

// File: rtl/strap_mux.sv
module strap_mux
  import strap_route_pkg::*;
#(
  parameter int unsigned MUX_W = 4
) (
  input  logic [MUX_W-1:0] reg_i,
  input  logic [MUX_W-1:0] ext_i,
  input  route_src_e       src_i,
  input  logic             force_n_i,
  output logic [MUX_W-1:0] out_o
);
  for (genvar g = 0; g < MUX_W; g++) begin : g_lane
    strap_lane u_lane (
      .reg_bit_i (reg_i[g]),
      .ext_bit_i (ext_i[g]),
      .src_i     (src_i),
      .force_n_i (force_n_i),
      .out_o     (out_o[g])
    );
  end
endmodule

// File: rtl/strap_hold.sv
module strap_hold
  import strap_route_pkg::*;
(
  input  logic rst_ni,
  input  logic d_i,
  input  logic force_n_i,
  input  logic open_i,
  output logic q_o
);
  logic d_vis;
  logic q_l;

  // capture the visible (already forced) value, not the raw stored bit
  assign d_vis = gate_bit(d_i, force_n_i);

  always_latch begin
    if (!rst_ni)     q_l = 1'b0;
    else if (open_i) q_l = d_vis;
  end

  assign q_o = q_l;
endmodule

// File: rtl/strap_route.sv
module strap_route
  import strap_route_pkg::*;
#(
  parameter int unsigned MUX_W = 4
) (
  input  logic             rst_ni,
  input  logic [MUX_W:0]   cfg_word_i,
  input  logic [MUX_W-1:0] ext_i,
  input  logic             use_ext_i,
  input  logic             force_n_i,
  output logic [MUX_W-1:0] route_o,
  output logic             held_o
);
  localparam int unsigned HeldIdx = MUX_W;

  route_src_e src;
  assign src = use_ext_i ? SRC_EXT : SRC_REG;

  strap_mux #(.MUX_W(MUX_W)) u_mux (
    .reg_i     (cfg_word_i[MUX_W-1:0]),
    .ext_i     (ext_i),
    .src_i     (src),
    .force_n_i (force_n_i),
    .out_o     (route_o)
  );

  strap_hold u_hold (
    .rst_ni    (rst_ni),
    .d_i       (cfg_word_i[HeldIdx]),
    .force_n_i (force_n_i),
    .open_i    (src == SRC_REG),
    .q_o       (held_o)
  );
endmodule

// File: rtl/strap_route_chk.sv
module strap_route_chk #(
  parameter int unsigned MUX_W = 4
) (
  input logic             rst_ni,
  input logic [MUX_W:0]   cfg_word_i,
  input logic [MUX_W-1:0] ext_i,
  input logic             use_ext_i,
  input logic             force_n_i,
  input logic [MUX_W-1:0] route_o,
  input logic             held_o
);
  // last value seen on held_o while the source was the stored word
  logic seen_l;
  always_latch begin
    if (!rst_ni)         seen_l = 1'b0;
    else if (!use_ext_i) seen_l = held_o;
  end

  always_comb begin
    if (!use_ext_i && force_n_i) begin
      p_reg_path_r1: assert (route_o == cfg_word_i[MUX_W-1:0]);
    end
    if (use_ext_i) begin
      p_ext_path_r2: assert (route_o == ext_i);
    end
    if (rst_ni && !use_ext_i && force_n_i) begin
      p_track_r3: assert (held_o == cfg_word_i[MUX_W]);
    end
    if (rst_ni && use_ext_i) begin
      p_hold_r4: assert (held_o == seen_l);
    end
    if (!use_ext_i && !force_n_i) begin
      p_force_zero_r5: assert (route_o == '0 && held_o == 1'b0);
    end
    if (!rst_ni) begin
      p_reset_clear_r8: assert (held_o == 1'b0);
    end
  end
endmodule

bind strap_route strap_route_chk #(.MUX_W(MUX_W)) u_chk (
  .rst_ni     (rst_ni),
  .cfg_word_i (cfg_word_i),
  .ext_i      (ext_i),
  .use_ext_i  (use_ext_i),
  .force_n_i  (force_n_i),
  .route_o    (route_o),
  .held_o     (held_o)
);

// File: tb/strap_route_tb_top.sv
`timescale 1ns/1ps
module strap_route_tb_top;
  localparam int unsigned MUX_W = 4;

  logic             clk;
  logic             rst_ni;
  logic [MUX_W:0]   cfg_word;
  logic [MUX_W-1:0] ext;
  logic             use_ext;
  logic             force_n;
  logic [MUX_W-1:0] route;
  logic             held;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  strap_route #(.MUX_W(MUX_W)) dut_i (
    .rst_ni     (rst_ni),
    .cfg_word_i (cfg_word),
    .ext_i      (ext),
    .use_ext_i  (use_ext),
    .force_n_i  (force_n),
    .route_o    (route),
    .held_o     (held)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling clock edge, sample a quarter period later
  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; cfg_word = 5'h1F; ext = 4'h0; use_ext = 1'b0; force_n = 1'b1;
    settle();
    chk("R8 held in reset, reg path", {7'd0, held}, 8'd0);
    use_ext = 1'b1;
    settle();
    chk("R8 held in reset, ext path", {7'd0, held}, 8'd0);
    use_ext = 1'b0;
    rst_ni = 1'b1;
    settle();
    chk("R3 held after reset release", {7'd0, held}, 8'd1);
  endtask

  task automatic t_reg_path();
    logic [4:0] pats [4] = '{5'h0A, 5'h05, 5'h1F, 5'h10};
    use_ext = 1'b0; force_n = 1'b1; ext = 4'h9;
    foreach (pats[i]) begin
      cfg_word = pats[i];
      settle();
      chk("R1 route from stored word", {4'd0, route}, {4'd0, pats[i][3:0]});
      chk("R3 held tracks bit4", {7'd0, held}, {7'd0, pats[i][4]});
    end
    cfg_word = 5'h01;
    settle();
    chk("R1 bit0 lands on route_o[0]", {7'd0, route[0]}, 8'd1);
  endtask

  task automatic t_ext_path();
    logic [3:0] pats [3] = '{4'h3, 4'hC, 4'h6};
    cfg_word = 5'h09; force_n = 1'b1; use_ext = 1'b1;
    foreach (pats[i]) begin
      ext = pats[i];
      settle();
      chk("R2 route from ext", {4'd0, route}, {4'd0, pats[i]});
    end
    force_n = 1'b0;
    ext = 4'hA;
    settle();
    chk("R2 ext path under force", {4'd0, route}, 8'h0A);
    force_n = 1'b1;
    use_ext = 1'b0;
    settle();
  endtask

  task automatic t_hold();
    use_ext = 1'b0; force_n = 1'b1; cfg_word = 5'h10;
    settle();
    use_ext = 1'b1;
    settle();
    cfg_word = 5'h00;
    settle();
    chk("R4 held frozen at 1", {7'd0, held}, 8'd1);
    cfg_word = 5'h1F;
    settle();
    cfg_word = 5'h0F;
    settle();
    chk("R4 held still 1 after rewrites", {7'd0, held}, 8'd1);
    use_ext = 1'b0;
    #1;
    chk("R7 held updates on select fall", {7'd0, held}, 8'd0);
    settle();
  endtask

  task automatic t_force_reg();
    use_ext = 1'b0; cfg_word = 5'h1B; force_n = 1'b0;
    settle();
    chk("R5 route forced", {4'd0, route}, 8'd0);
    chk("R5 held forced", {7'd0, held}, 8'd0);
    force_n = 1'b1;
    settle();
    chk("R1 route after force release", {4'd0, route}, 8'h0B);
  endtask

  task automatic t_force_ext();
    use_ext = 1'b0; force_n = 1'b1; cfg_word = 5'h10; ext = 4'h5;
    settle();
    use_ext = 1'b1;
    settle();
    force_n = 1'b0;
    settle();
    chk("R6 route unaffected by force", {4'd0, route}, 8'h05);
    chk("R6 held unaffected by force", {7'd0, held}, 8'd1);
    force_n = 1'b1;
    use_ext = 1'b0;
    settle();
  endtask

  task automatic t_capture_forced();
    use_ext = 1'b0; force_n = 1'b0; cfg_word = 5'h10; ext = 4'h2;
    settle();
    use_ext = 1'b1;
    settle();
    force_n = 1'b1;
    settle();
    chk("R6 forced zero captured", {7'd0, held}, 8'd0);
    use_ext = 1'b0;
    #1;
    chk("R7 held takes bit4 after release", {7'd0, held}, 8'd1);
    settle();
  endtask

  initial begin
    t_reset();
    t_reg_path();
    t_ext_path();
    t_hold();
    t_force_reg();
    t_force_ext();
    t_capture_forced();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule